// File: doc/BRIEF.md
# Rank-Ordered Insertion Queue

This block is a hardware queue that keeps its entries sorted by a numeric rank. Each arriving entry is written straight into the slot that its rank selects, while the departure side only ever removes the entry at the head. The head always holds the smallest rank stored. Entries that are already queued never change their order relative to each other, so later arrivals can only move in between them.

Every entry carries a kind bit and a tag. The kind bit says whether the tag names a packet descriptor or refers to another queue of the same type. A scheduler that dequeues a queue reference then continues the dequeue in the referenced queue, which lets several instances form a scheduling tree.

On a push, the incoming rank is compared with every stored rank in the same cycle. Each slot then either keeps its contents, takes the new entry, or takes the contents of a neighbouring slot. A push and a pop can happen in the same cycle. The capacity and the widths of the rank and tag are parameters.

Top module: `rank_sort_queue`

## Requirements
- R1: After reset the queue is empty. `count` is 0, `empty` is 1, `full` is 0, and `popValid` stays low even while `popReq` is high.
- R2: Entries leave in ascending rank order, regardless of the order in which they were pushed.
- R3: Entries of equal rank leave in the order they arrived. A new entry is placed behind every stored entry whose rank is less than or equal to its own.
- R4: The kind bit (0 = packet descriptor, 1 = reference to another queue) and the tag come out exactly as they were pushed with that entry.
- R5: When `count` equals DEPTH, `full` is 1. A push in that state raises `pushDrop` in the same cycle, and the stored contents and `count` are left unchanged, even if the pushed rank is smaller than every stored rank.
- R6: A pop request while the queue is empty leaves `popValid` low, and `count` and the contents unchanged.
- R7: A push and a pop in the same cycle on a non-empty queue return the old head. They also insert the new entry at its sorted place among the remaining entries, and `count` does not change.
- R8: A push and a pop in the same cycle on an empty queue store the new entry but do not return it. `popValid` stays low and `count` becomes 1.
- R9: `count` equals the number of stored entries. `empty` is 1 exactly when `count` is 0, and `full` is 1 exactly when `count` is DEPTH.
- R10: `popValid`, `popRank`, `popKind` and `popTag` answer `popReq` in the same cycle, with the head entry as it stands before the clock edge. The removal takes effect at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| pushValid | input | 1 | Push request |
| pushRank | input | RANK_W | Rank of the pushed entry |
| pushKind | input | 1 | 0 = packet descriptor, 1 = queue reference |
| pushTag | input | TAG_W | Tag of the pushed entry |
| pushDrop | output | 1 | Push rejected because the queue is full |
| popReq | input | 1 | Pop request |
| popValid | output | 1 | A head entry is returned this cycle |
| popRank | output | RANK_W | Rank of the head entry |
| popKind | output | 1 | Kind bit of the head entry |
| popTag | output | TAG_W | Tag of the head entry |
| count | output | $clog2(DEPTH+1) | Number of stored entries |
| full | output | 1 | Queue holds DEPTH entries |
| empty | output | 1 | Queue holds no entry |

## Verification
The checker watches the status and handshake rules on every cycle:
- a push into a full queue is dropped, and a drop only happens when the queue is full;
- the occupancy moves by exactly one step per push or pop, and is unchanged when a push and a pop meet;
- an empty queue never answers a pop, not even during a simultaneous push;
- after a pop-only cycle the head rank never decreases.

Other properties need a full history of what was pushed, so only the bench's scenarios can show them. These are the exact position chosen for each arrival, the first-come order among equal ranks, and the kind bit and tag surviving the shifts. The bench therefore runs sequences with known expected departure orders, including interleaved push-and-pop cycles and a push against a full queue.

// File: rtl/rank_sort_pkg.sv
package rank_sort_pkg;

  // Strobes from control to the slot array.
  typedef struct packed {
    logic push;  // accepted push this cycle
    logic pop;   // accepted pop this cycle
  } sortStrobe_t;

  // Per-slot source selection for the next state.
  typedef enum logic [1:0] {
    SEL_KEEP = 2'd0,  // slot keeps its contents
    SEL_UP   = 2'd1,  // slot takes the entry behind it (queue moves forward)
    SEL_DOWN = 2'd2,  // slot takes the entry ahead of it (queue opens a gap)
    SEL_NEW  = 2'd3   // slot takes the incoming entry
  } slotSel_t;

endpackage

// File: rtl/rank_sort_ctrl.sv
module rank_sort_ctrl
  import rank_sort_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             pushValid,
  input  logic             popReq,
  output sortStrobe_t      strobe,
  output logic [CNT_W-1:0] count,
  output logic             full,
  output logic             empty,
  output logic             pushDrop,
  output logic             popValid
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic [CNT_W-1:0] countQ;
  logic [CNT_W-1:0] countD;

  assign full  = (countQ == CNT_MAX);
  assign empty = (countQ == '0);

  // A full queue rejects a push even when a pop arrives in the same cycle.
  assign strobe.push = pushValid && !full;
  assign strobe.pop  = popReq && !empty;

  assign pushDrop = pushValid && full;
  assign popValid = strobe.pop;
  assign count    = countQ;

  always_comb begin
    countD = countQ;
    unique case ({strobe.push, strobe.pop})
      2'b10:   countD = countQ + CNT_ONE;
      2'b01:   countD = countQ - CNT_ONE;
      default: countD = countQ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) countQ <= '0;
    else       countQ <= countD;
  end

endmodule

// File: rtl/rank_sort_array.sv
module rank_sort_array
  import rank_sort_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int RANK_W = 16,
  parameter int TAG_W  = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  sortStrobe_t       strobe,
  input  logic [CNT_W-1:0]  count,
  input  logic [RANK_W-1:0] pushRank,
  input  logic              pushKind,
  input  logic [TAG_W-1:0]  pushTag,
  output logic [RANK_W-1:0] headRank,
  output logic              headKind,
  output logic [TAG_W-1:0]  headTag
);

  logic [RANK_W-1:0] rankQ [DEPTH];
  logic              kindQ [DEPTH];
  logic [TAG_W-1:0]  tagQ  [DEPTH];

  logic [RANK_W-1:0] rankD [DEPTH];
  logic              kindD [DEPTH];
  logic [TAG_W-1:0]  tagD  [DEPTH];

  // leMask[i]: slot i is occupied and its rank is <= the incoming rank.
  // The queue is sorted, so the mask is a run of ones from slot 0.
  logic [DEPTH:0] leMask;
  assign leMask[DEPTH] = 1'b0;

  for (genvar g = 0; g < DEPTH; g++) begin : gSlot
    logic              leNext;
    logic              lePrev;
    logic [RANK_W-1:0] upRank;
    logic              upKind;
    logic [TAG_W-1:0]  upTag;
    logic [RANK_W-1:0] downRank;
    logic              downKind;
    logic [TAG_W-1:0]  downTag;
    slotSel_t          sel;

    assign leMask[g] = (count > CNT_W'(g)) && (rankQ[g] <= pushRank);
    assign leNext    = leMask[g+1];

    if (g == DEPTH - 1) begin : gLast
      assign upRank = rankQ[g];
      assign upKind = kindQ[g];
      assign upTag  = tagQ[g];
    end else begin : gMid
      assign upRank = rankQ[g+1];
      assign upKind = kindQ[g+1];
      assign upTag  = tagQ[g+1];
    end

    if (g == 0) begin : gHead
      assign lePrev   = 1'b1;
      assign downRank = rankQ[g];
      assign downKind = kindQ[g];
      assign downTag  = tagQ[g];
    end else begin : gBody
      assign lePrev   = leMask[g-1];
      assign downRank = rankQ[g-1];
      assign downKind = kindQ[g-1];
      assign downTag  = tagQ[g-1];
    end

    always_comb begin
      sel = SEL_KEEP;
      unique case ({strobe.push, strobe.pop})
        2'b11: begin
          // Head leaves; the new entry lands among the survivors.
          if (leNext)                     sel = SEL_UP;
          else if (g == 0 || leMask[g])   sel = SEL_NEW;
          else                            sel = SEL_KEEP;
        end
        2'b10: begin
          if (leMask[g])                  sel = SEL_KEEP;
          else if (lePrev)                sel = SEL_NEW;
          else                            sel = SEL_DOWN;
        end
        2'b01:   sel = SEL_UP;
        default: sel = SEL_KEEP;
      endcase
    end

    always_comb begin
      unique case (sel)
        SEL_UP: begin
          rankD[g] = upRank;   kindD[g] = upKind;   tagD[g] = upTag;
        end
        SEL_DOWN: begin
          rankD[g] = downRank; kindD[g] = downKind; tagD[g] = downTag;
        end
        SEL_NEW: begin
          rankD[g] = pushRank; kindD[g] = pushKind; tagD[g] = pushTag;
        end
        default: begin
          rankD[g] = rankQ[g]; kindD[g] = kindQ[g]; tagD[g] = tagQ[g];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++) begin
      if (!rstN) begin
        rankQ[i] <= '0;
        kindQ[i] <= 1'b0;
        tagQ[i]  <= '0;
      end else begin
        rankQ[i] <= rankD[i];
        kindQ[i] <= kindD[i];
        tagQ[i]  <= tagD[i];
      end
    end
  end

  assign headRank = rankQ[0];
  assign headKind = kindQ[0];
  assign headTag  = tagQ[0];

endmodule

// File: rtl/rank_sort_queue.sv
module rank_sort_queue
  import rank_sort_pkg::*;
#(
  parameter int DEPTH  = 128,
  parameter int RANK_W = 16,
  parameter int TAG_W  = 12,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pushValid,
  input  logic [RANK_W-1:0] pushRank,
  input  logic              pushKind,
  input  logic [TAG_W-1:0]  pushTag,
  output logic              pushDrop,
  input  logic              popReq,
  output logic              popValid,
  output logic [RANK_W-1:0] popRank,
  output logic              popKind,
  output logic [TAG_W-1:0]  popTag,
  output logic [CNT_W-1:0]  count,
  output logic              full,
  output logic              empty
);

  sortStrobe_t strobe;

  rank_sort_ctrl #(
    .DEPTH (DEPTH),
    .CNT_W (CNT_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .pushValid (pushValid),
    .popReq    (popReq),
    .strobe    (strobe),
    .count     (count),
    .full      (full),
    .empty     (empty),
    .pushDrop  (pushDrop),
    .popValid  (popValid)
  );

  rank_sort_array #(
    .DEPTH  (DEPTH),
    .RANK_W (RANK_W),
    .TAG_W  (TAG_W),
    .CNT_W  (CNT_W)
  ) uArray (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .count    (count),
    .pushRank (pushRank),
    .pushKind (pushKind),
    .pushTag  (pushTag),
    .headRank (popRank),
    .headKind (popKind),
    .headTag  (popTag)
  );

endmodule

// File: rtl/rank_sort_checker.sv
module rank_sort_checker #(
  parameter int DEPTH  = 128,
  parameter int RANK_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              pushValid,
  input logic              pushDrop,
  input logic              popReq,
  input logic              popValid,
  input logic [RANK_W-1:0] popRank,
  input logic [CNT_W-1:0]  count,
  input logic              full,
  input logic              empty
);

  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(DEPTH);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  // R5: a push into a full queue is dropped
  p_drop_when_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && full) |-> pushDrop);

  // R5: drops happen only when full
  p_drop_needs_full_r5: assert property (@(posedge clk) disable iff (!rstN)
    pushDrop |-> (full && pushValid));

  // R5: a dropped push without a pop leaves occupancy unchanged
  p_full_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (pushDrop && !popReq) |=> (full && count == CNT_MAX));

  // R6: an empty queue never answers a pop
  p_no_pop_empty_r6: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && empty) |-> !popValid);

  // R6: idle empty queue stays empty
  p_empty_stays_r6: assert property (@(posedge clk) disable iff (!rstN)
    (empty && !pushValid) |=> empty);

  // R8: no same-cycle bypass on an empty queue; the push is still stored
  p_no_bypass_r8: assert property (@(posedge clk) disable iff (!rstN)
    (empty && pushValid && popReq) |=> (count == CNT_ONE));

  // R7: a push meeting a pop keeps the occupancy
  p_swap_count_r7: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && pushValid && !pushDrop) |=> (count == $past(count)));

  // R9: occupancy rises by one on a lone accepted push
  p_count_up_r9: assert property (@(posedge clk) disable iff (!rstN)
    (pushValid && !pushDrop && !popValid) |=> (count == $past(count) + CNT_ONE));

  // R9: occupancy falls by one on a lone pop
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !pushValid) |=> (count == $past(count) - CNT_ONE));

  // R9: status flags consistent with the bound
  p_status_bound_r9: assert property (@(posedge clk) disable iff (!rstN)
    (count <= CNT_MAX) && !(full && empty));

  // R10: a pop on a non-empty queue is answered in the same cycle
  p_pop_live_r10: assert property (@(posedge clk) disable iff (!rstN)
    (popReq && !empty) |-> popValid);

  // R2: after a pop-only cycle the head rank does not decrease
  p_head_order_r2: assert property (@(posedge clk) disable iff (!rstN)
    (popValid && !pushValid && count > CNT_ONE) |=> (!empty && popRank >= $past(popRank)));

endmodule

bind rank_sort_queue rank_sort_checker #(
  .DEPTH  (DEPTH),
  .RANK_W (RANK_W),
  .CNT_W  (CNT_W)
) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .pushValid (pushValid),
  .pushDrop  (pushDrop),
  .popReq    (popReq),
  .popValid  (popValid),
  .popRank   (popRank),
  .count     (count),
  .full      (full),
  .empty     (empty)
);

// File: tb/tb_rank_sort_queue.sv
module tb_rank_sort_queue;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 8;
  localparam int RANK_W = 16;
  localparam int TAG_W  = 12;
  localparam int CNT_W  = $clog2(DEPTH + 1);
  localparam int NVEC   = 14;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              pushValid = 1'b0;
  logic [RANK_W-1:0] pushRank = '0;
  logic              pushKind = 1'b0;
  logic [TAG_W-1:0]  pushTag = '0;
  logic              pushDrop;
  logic              popReq = 1'b0;
  logic              popValid;
  logic [RANK_W-1:0] popRank;
  logic              popKind;
  logic [TAG_W-1:0]  popTag;
  logic [CNT_W-1:0]  count;
  logic              full;
  logic              empty;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  rank_sort_queue #(
    .DEPTH (DEPTH), .RANK_W (RANK_W), .TAG_W (TAG_W)
  ) dut (
    .clk (clk), .rstN (rstN),
    .pushValid (pushValid), .pushRank (pushRank), .pushKind (pushKind),
    .pushTag (pushTag), .pushDrop (pushDrop),
    .popReq (popReq), .popValid (popValid), .popRank (popRank),
    .popKind (popKind), .popTag (popTag),
    .count (count), .full (full), .empty (empty)
  );

  typedef struct packed {
    logic [3:0]  req;
    logic        pv;
    logic [15:0] rank;
    logic        kind;
    logic [11:0] tag;
    logic        pr;
    logic        expValid;
    logic [15:0] expRank;
    logic        expKind;
    logic [11:0] expTag;
    logic [3:0]  expCount;  // occupancy before the edge of this step
  } vec_t;

  // Hand-computed from the requirements; state after each step in comments.
  localparam vec_t VECS [NVEC] = '{
    '{4'd2,  1'b1, 16'd50, 1'b0, 12'd1, 1'b0, 1'b0, 16'd0,  1'b0, 12'd0, 4'd0}, // [50/1]
    '{4'd2,  1'b1, 16'd20, 1'b0, 12'd2, 1'b0, 1'b0, 16'd0,  1'b0, 12'd0, 4'd1}, // [20/2 50/1]
    '{4'd3,  1'b1, 16'd50, 1'b0, 12'd3, 1'b0, 1'b0, 16'd0,  1'b0, 12'd0, 4'd2}, // [20 50/1 50/3]
    '{4'd4,  1'b1, 16'd35, 1'b1, 12'd4, 1'b0, 1'b0, 16'd0,  1'b0, 12'd0, 4'd3}, // [20 35/4 50/1 50/3]
    '{4'd2,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b1, 16'd20, 1'b0, 12'd2, 4'd4}, // [35/4 50/1 50/3]
    '{4'd4,  1'b1, 16'd10, 1'b0, 12'd5, 1'b1, 1'b1, 16'd35, 1'b1, 12'd4, 4'd3}, // [10/5 50/1 50/3]
    '{4'd7,  1'b1, 16'd60, 1'b0, 12'd6, 1'b1, 1'b1, 16'd10, 1'b0, 12'd5, 4'd3}, // [50/1 50/3 60/6]
    '{4'd7,  1'b1, 16'd50, 1'b0, 12'd7, 1'b1, 1'b1, 16'd50, 1'b0, 12'd1, 4'd3}, // [50/3 50/7 60/6]
    '{4'd3,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b1, 16'd50, 1'b0, 12'd3, 4'd3}, // [50/7 60/6]
    '{4'd3,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b1, 16'd50, 1'b0, 12'd7, 4'd2}, // [60/6]
    '{4'd2,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b1, 16'd60, 1'b0, 12'd6, 4'd1}, // []
    '{4'd6,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b0, 16'd0,  1'b0, 12'd0, 4'd0}, // []
    '{4'd8,  1'b1, 16'd5,  1'b1, 12'd8, 1'b1, 1'b0, 16'd0,  1'b0, 12'd0, 4'd0}, // [5/8]
    '{4'd8,  1'b0, 16'd0,  1'b0, 12'd0, 1'b1, 1'b1, 16'd5,  1'b1, 12'd8, 4'd1}  // []
  };

  function automatic string reqName(input logic [3:0] id);
    case (id)
      4'd2:    return "R2";
      4'd3:    return "R3";
      4'd4:    return "R4";
      4'd6:    return "R6";
      4'd7:    return "R7";
      4'd8:    return "R8";
      default: return "R10";
    endcase
  endfunction

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic pv, input logic [RANK_W-1:0] rk, input logic kd,
                       input logic [TAG_W-1:0] tg, input logic pr);
    @(negedge clk);
    pushValid = pv; pushRank = rk; pushKind = kd; pushTag = tg; popReq = pr;
    #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R1: reset state, with a pop request held high
    drive(1'b0, '0, 1'b0, '0, 1'b1);
    rstN = 1'b1;
    #1;
    check("R1", "count", 32'(count), 0);
    check("R1", "empty", 32'(empty), 1);
    check("R1", "full", 32'(full), 0);
    check("R1", "popValid", 32'(popValid), 0);

    // Table walk
    for (int v = 0; v < NVEC; v++) begin
      drive(VECS[v].pv, VECS[v].rank, VECS[v].kind, VECS[v].tag, VECS[v].pr);
      check("R9", "count", 32'(count), 32'(VECS[v].expCount));
      check("R10", "popValid", 32'(popValid), 32'(VECS[v].expValid));
      check("R5", "pushDrop", 32'(pushDrop), 0);
      if (VECS[v].expValid) begin
        check(reqName(VECS[v].req), "popRank", 32'(popRank), 32'(VECS[v].expRank));
        check("R4", "popKind", 32'(popKind), 32'(VECS[v].expKind));
        check(reqName(VECS[v].req), "popTag", 32'(popTag), 32'(VECS[v].expTag));
      end
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R9", "count after table", 32'(count), 0);
    check("R9", "empty after table", 32'(empty), 1);

    // Fill with descending ranks 80..10, tags 100..107
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b1, RANK_W'(80 - 10 * k), 1'b0, TAG_W'(100 + k), 1'b0);
      check("R5", "no drop while filling", 32'(pushDrop), 0);
    end
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R9", "count when full", 32'(count), DEPTH);
    check("R9", "full flag", 32'(full), 1);
    check("R9", "empty flag", 32'(empty), 0);

    // R5: push into full queue with a rank smaller than all stored ranks
    drive(1'b1, RANK_W'(1), 1'b1, TAG_W'(999), 1'b0);
    check("R5", "pushDrop on full", 32'(pushDrop), 1);
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R5", "count unchanged", 32'(count), DEPTH);
    check("R5", "head rank unchanged", 32'(popRank), 10);
    check("R5", "head tag unchanged", 32'(popTag), 107);

    // Drain: ascending ranks 10..80, tags 107..100
    for (int k = 0; k < DEPTH; k++) begin
      drive(1'b0, '0, 1'b0, '0, 1'b1);
      check("R2", "drain popValid", 32'(popValid), 1);
      check("R2", "drain rank", 32'(popRank), 32'(10 + 10 * k));
      check("R4", "drain tag", 32'(popTag), 32'(107 - k));
    end
    drive(1'b0, '0, 1'b0, '0, 1'b1);
    check("R6", "pop on drained queue", 32'(popValid), 0);
    check("R6", "count stays zero", 32'(count), 0);
    drive(1'b0, '0, 1'b0, '0, 1'b0);
    check("R6", "still empty", 32'(empty), 1);

    finishRun();
  end

endmodule